// File: doc/BRIEF.md
# Shared Set-Associative Translation Buffer with Thread Ownership

This block caches virtual-to-physical page translations for several requesters that share one table. Each requester presents a virtual address together with the address-space ID and the thread ID it runs under. One cycle later the block reports one of three outcomes: a hit carrying the physical address, an ownership fault, or a miss. Pages are 4 KB. The table has 32 sets of 8 ways, and the set is picked by the low five bits of the virtual page number.

Every entry stores an address-space ID and an owner field. An owner value of zero leaves the page open to every thread of that address space. A nonzero owner value limits the page to the thread whose ID equals it. Translations are installed through a write port. A flush port invalidates either the whole table or every entry of one address space, and it never looks at the owner field. When two requesters ask in the same cycle, the lower-numbered one is served first and the other is held with a stall.

Top module: `shared_tlb`

## Requirements
- R1: After reset every entry is invalid: `rsp_valid` and `req_stall` are all zero, and the first lookup misses.
- R2: A granted lookup raises the `rsp_valid` bit of its own requester exactly one cycle later. The lookup sees the table as it was before any write or flush in that same cycle.
- R3: When several requests are valid, only the lowest-numbered one is granted. Every other valid request sees `req_stall` high and must hold its inputs until it is granted.
- R4: A hit needs a valid entry whose tag and ASID match, and whose owner field is zero or equal to the thread ID. A hit gives `rsp_hit`=1 and `rsp_pa` = {entry PPN, VA[11:0]}.
- R5: An entry whose tag matches but whose ASID differs gives a miss.
- R6: An entry whose tag and ASID match, but whose owner field is nonzero and differs from the thread ID, gives `rsp_fault`=1, `rsp_hit`=0 and `rsp_pa`=0.
- R7: A miss gives `rsp_hit`=0, `rsp_fault`=0 and `rsp_pa`=0.
- R8: A write goes to set VPN[4:0]. If that set has an invalid way and holds no entry with the same VPN and ASID, the write fills the lowest-numbered invalid way.
- R9: If the set is full and holds no entry with the same VPN and ASID, the write replaces the way named by that set's 3-bit round-robin pointer. The pointer starts at 0 and steps by one after each such replacement.
- R10: A write whose VPN and ASID match a valid entry overwrites that way in place and leaves the round-robin pointer unchanged.
- R11: A flush by ASID invalidates every entry with that ASID, whatever its owner field. Entries of other ASIDs are left untouched.
- R12: A flush of everything invalidates all entries. A write in the same cycle as a flush is installed after the flush and stays valid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NREQ | Lookup request, one bit per requester |
| req_va | input | NREQ*32 | Virtual address per requester |
| req_asid | input | NREQ*8 | Current address-space ID per requester |
| req_tid | input | NREQ*4 | Current thread ID per requester |
| req_stall | output | NREQ | Request is valid but not granted this cycle |
| rsp_valid | output | NREQ | One-hot: the response belongs to this requester |
| rsp_hit | output | 1 | Translation found and the thread may use it |
| rsp_fault | output | 1 | Translation found but owned by another thread |
| rsp_pa | output | 32 | Physical address on a hit, zero otherwise |
| wr_en | input | 1 | Install a translation |
| wr_vpn | input | 20 | Virtual page number to install |
| wr_asid | input | 8 | ASID of the new entry |
| wr_sasid | input | 4 | Owner thread of the new entry, 0 for any thread |
| wr_ppn | input | 20 | Physical page number of the new entry |
| flush_en | input | 1 | Perform a flush |
| flush_all | input | 1 | With flush_en: invalidate every entry |
| flush_asid | input | 8 | With flush_en and not flush_all: ASID to invalidate |

## Verification
Most internal errors in this block do not show up at once. They appear only at the first lookup that touches the damaged entry. A valid bit that a flush failed to clear shows as a hit one cycle after the next lookup of that page, where a miss was expected. A round-robin pointer that moves at the wrong time stays hidden until the next write into a full set, and then it shows as the wrong page surviving. For that reason the sequences fill a set, replace entries in it, overwrite an entry in place, and then probe every page that could have been evicted. A wrong grant is visible in the same cycle on `req_stall`, and a cycle later on which `rsp_valid` bit rises.

// File: rtl/tlb_pkg.sv
package tlb_pkg;

    localparam int VA_W      = 32;
    localparam int PA_W      = 32;
    localparam int PAGE_BITS = 12;
    localparam int ASID_W    = 8;
    localparam int TID_W     = 4;
    localparam int SETS      = 32;
    localparam int WAYS      = 8;

    localparam int VPN_W = VA_W - PAGE_BITS;
    localparam int PPN_W = PA_W - PAGE_BITS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = VPN_W - IDX_W;
    localparam int WAY_W = $clog2(WAYS);

    typedef struct packed {
        logic              valid;
        logic [TAG_W-1:0]  tag;
        logic [ASID_W-1:0] asid;
        logic [TID_W-1:0]  owner;
        logic [PPN_W-1:0]  ppn;
    } tlb_entry_t;

    typedef struct packed {
        logic [VPN_W-1:0]     vpn;
        logic [PAGE_BITS-1:0] offset;
        logic [ASID_W-1:0]    asid;
        logic [TID_W-1:0]     tid;
    } tlb_query_t;

    typedef struct packed {
        logic            hit;
        logic            fault;
        logic [PA_W-1:0] pa;
    } tlb_result_t;

    function automatic logic [IDX_W-1:0] set_of(input logic [VPN_W-1:0] vpn);
        return vpn[IDX_W-1:0];
    endfunction

    function automatic logic [TAG_W-1:0] tag_of(input logic [VPN_W-1:0] vpn);
        return vpn[VPN_W-1:IDX_W];
    endfunction

    // zero owner: open to every thread of the address space
    function automatic logic owner_ok(input logic [TID_W-1:0] owner,
                                      input logic [TID_W-1:0] tid);
        return (owner == '0) || (owner == tid);
    endfunction

endpackage

// File: rtl/tlb_grant.sv
module tlb_grant #(
    parameter int NREQ = 2,
    localparam int GID_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic [NREQ-1:0]  req,
    output logic [NREQ-1:0]  grant,
    output logic [GID_W-1:0] gid,
    output logic             any
);

    // fixed priority: lowest index wins
    always_comb begin
        grant = '0;
        gid   = '0;
        any   = 1'b0;
        for (int i = 0; i < NREQ; i++) begin
            if (req[i] && !any) begin
                grant[i] = 1'b1;
                gid      = GID_W'(i);
                any      = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_probe.sv
module tlb_probe
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] row,
    input  logic [TAG_W-1:0]      tag,
    input  tlb_query_t            qry,
    output tlb_result_t           res
);

    logic       matched;
    tlb_entry_t sel;

    always_comb begin
        matched = 1'b0;
        sel     = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!matched && row[w].valid && row[w].tag == tag && row[w].asid == qry.asid) begin
                matched = 1'b1;
                sel     = row[w];
            end
        end
    end

    always_comb begin
        res = '0;
        if (matched) begin
            if (owner_ok(sel.owner, qry.tid)) begin
                res.hit = 1'b1;
                res.pa  = {sel.ppn, qry.offset};
            end else begin
                res.fault = 1'b1;
            end
        end
    end

endmodule

// File: rtl/tlb_victim.sv
module tlb_victim
    import tlb_pkg::*;
(
    input  tlb_entry_t [WAYS-1:0] row,
    input  logic [TAG_W-1:0]      tag,
    input  logic [ASID_W-1:0]     asid,
    input  logic [WAY_W-1:0]      rr_ptr,
    output logic [WAY_W-1:0]      way,
    output logic                  advance
);

    logic             same_f, free_f;
    logic [WAY_W-1:0] same_w, free_w;

    always_comb begin
        same_f = 1'b0;
        free_f = 1'b0;
        same_w = '0;
        free_w = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (!same_f && row[w].valid && row[w].tag == tag && row[w].asid == asid) begin
                same_f = 1'b1;
                same_w = WAY_W'(w);
            end
            if (!free_f && !row[w].valid) begin
                free_f = 1'b1;
                free_w = WAY_W'(w);
            end
        end
    end

    // order of choice: in-place overwrite, free way, round-robin victim
    always_comb begin
        advance = 1'b0;
        if (same_f) begin
            way = same_w;
        end else if (free_f) begin
            way = free_w;
        end else begin
            way     = rr_ptr;
            advance = 1'b1;
        end
    end

endmodule

// File: rtl/shared_tlb.sv
module shared_tlb
    import tlb_pkg::*;
#(
    parameter int NREQ = 2,
    localparam int GID_W = (NREQ > 1) ? $clog2(NREQ) : 1
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic [NREQ-1:0]        req_valid,
    input  logic [NREQ*VA_W-1:0]   req_va,
    input  logic [NREQ*ASID_W-1:0] req_asid,
    input  logic [NREQ*TID_W-1:0]  req_tid,
    output logic [NREQ-1:0]        req_stall,
    output logic [NREQ-1:0]        rsp_valid,
    output logic                   rsp_hit,
    output logic                   rsp_fault,
    output logic [PA_W-1:0]        rsp_pa,
    input  logic                   wr_en,
    input  logic [VPN_W-1:0]       wr_vpn,
    input  logic [ASID_W-1:0]      wr_asid,
    input  logic [TID_W-1:0]       wr_sasid,
    input  logic [PPN_W-1:0]       wr_ppn,
    input  logic                   flush_en,
    input  logic                   flush_all,
    input  logic [ASID_W-1:0]      flush_asid
);

    tlb_entry_t [WAYS-1:0] tbl    [SETS];
    logic [WAY_W-1:0]      rr_ptr [SETS];

    // request selection
    logic [NREQ-1:0]  grant;
    logic [GID_W-1:0] gid;
    logic             any;

    tlb_grant #(.NREQ(NREQ)) u_grant (
        .req   (req_valid),
        .grant (grant),
        .gid   (gid),
        .any   (any)
    );

    assign req_stall = req_valid & ~grant;

    tlb_query_t       qry;
    logic [IDX_W-1:0] q_set;
    logic [TAG_W-1:0] q_tag;

    always_comb begin
        qry.vpn    = req_va[gid*VA_W + PAGE_BITS +: VPN_W];
        qry.offset = req_va[gid*VA_W +: PAGE_BITS];
        qry.asid   = req_asid[gid*ASID_W +: ASID_W];
        qry.tid    = req_tid[gid*TID_W +: TID_W];
    end

    assign q_set = set_of(qry.vpn);
    assign q_tag = tag_of(qry.vpn);

    tlb_result_t probe_res;

    tlb_probe u_probe (
        .row (tbl[q_set]),
        .tag (q_tag),
        .qry (qry),
        .res (probe_res)
    );

    // response register
    tlb_result_t     rsp_q;
    logic [NREQ-1:0] rsp_v_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            rsp_v_q <= '0;
            rsp_q   <= '0;
        end else begin
            rsp_v_q <= grant;
            rsp_q   <= any ? probe_res : '0;
        end
    end

    assign rsp_valid = rsp_v_q;
    assign rsp_hit   = rsp_q.hit;
    assign rsp_fault = rsp_q.fault;
    assign rsp_pa    = rsp_q.pa;

    // write path
    logic [IDX_W-1:0] w_set;
    logic [TAG_W-1:0] w_tag;
    logic [WAY_W-1:0] w_way;
    logic             w_adv;
    tlb_entry_t       w_ent;

    assign w_set = set_of(wr_vpn);
    assign w_tag = tag_of(wr_vpn);

    tlb_victim u_victim (
        .row     (tbl[w_set]),
        .tag     (w_tag),
        .asid    (wr_asid),
        .rr_ptr  (rr_ptr[w_set]),
        .way     (w_way),
        .advance (w_adv)
    );

    always_comb begin
        w_ent.valid = 1'b1;
        w_ent.tag   = w_tag;
        w_ent.asid  = wr_asid;
        w_ent.owner = wr_sasid;
        w_ent.ppn   = wr_ppn;
    end

    // flush acts first; a write in the same cycle lands afterwards
    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < SETS; s++) begin
                tbl[s]    <= '0;
                rr_ptr[s] <= '0;
            end
        end else begin
            if (flush_en) begin
                for (int s = 0; s < SETS; s++) begin
                    for (int w = 0; w < WAYS; w++) begin
                        if (flush_all || tbl[s][w].asid == flush_asid) begin
                            tbl[s][w].valid <= 1'b0;
                        end
                    end
                end
            end
            if (wr_en) begin
                tbl[w_set][w_way] <= w_ent;
                if (w_adv) begin
                    rr_ptr[w_set] <= rr_ptr[w_set] + 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/shared_tlb_chk.sv
module shared_tlb_chk
    import tlb_pkg::*;
#(
    parameter int NREQ = 2
) (
    input logic            clk,
    input logic            rst,
    input logic [NREQ-1:0] req_valid,
    input logic [NREQ-1:0] req_stall,
    input logic [NREQ-1:0] rsp_valid,
    input logic            rsp_hit,
    input logic            rsp_fault,
    input logic [PA_W-1:0] rsp_pa
);

    // R3
    one_grant_chk: assert property (@(posedge clk) disable iff (rst)
        (req_valid != '0) |-> ($countones(req_valid & ~req_stall) == 1));

    // R3
    stall_has_req_chk: assert property (@(posedge clk) disable iff (rst)
        ((req_stall & ~req_valid) == '0));

    // R2
    rsp_after_grant_chk: assert property (@(posedge clk) disable iff (rst)
        !rst |=> (rsp_valid == $past(req_valid & ~req_stall)));

    // R2
    rsp_onehot_chk: assert property (@(posedge clk) disable iff (rst)
        $onehot0(rsp_valid));

    // R6
    hit_fault_excl_chk: assert property (@(posedge clk) disable iff (rst)
        !(rsp_hit && rsp_fault));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (rsp_valid == '0) |-> (!rsp_hit && !rsp_fault));

    // R6
    pa_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !rsp_hit |-> (rsp_pa == '0));

endmodule

bind shared_tlb shared_tlb_chk #(.NREQ(NREQ)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_stall (req_stall),
    .rsp_valid (rsp_valid),
    .rsp_hit   (rsp_hit),
    .rsp_fault (rsp_fault),
    .rsp_pa    (rsp_pa)
);

// File: tb/shared_tlb_tb.sv
module shared_tlb_tb;
    import tlb_pkg::*;

    localparam int NREQ = 2;

    logic                   clk = 1'b0;
    logic                   rst;
    logic [NREQ-1:0]        req_valid;
    logic [NREQ*VA_W-1:0]   req_va;
    logic [NREQ*ASID_W-1:0] req_asid;
    logic [NREQ*TID_W-1:0]  req_tid;
    logic [NREQ-1:0]        req_stall;
    logic [NREQ-1:0]        rsp_valid;
    logic                   rsp_hit;
    logic                   rsp_fault;
    logic [PA_W-1:0]        rsp_pa;
    logic                   wr_en;
    logic [VPN_W-1:0]       wr_vpn;
    logic [ASID_W-1:0]      wr_asid;
    logic [TID_W-1:0]       wr_sasid;
    logic [PPN_W-1:0]       wr_ppn;
    logic                   flush_en;
    logic                   flush_all;
    logic [ASID_W-1:0]      flush_asid;

    always #4 clk = ~clk;

    shared_tlb #(.NREQ(NREQ)) u_dut (.*);

    typedef struct {
        bit              hit;
        bit              fault;
        logic [PA_W-1:0] pa;
        string           rq;
    } exp_t;

    exp_t q0[$];
    exp_t q1[$];
    int n_chk  = 0;
    int n_fail = 0;

    task automatic chk(input bit ok, input string rq, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0h expected %0h", rq, what, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        exp_t e;
        if (!rst) begin
            for (int i = 0; i < NREQ; i++) begin
                if (rsp_valid[i]) begin
                    if ((i == 0 ? q0.size() : q1.size()) == 0) begin
                        chk(1'b0, "R2", "unexpected response", 64'(i), 64'hff);
                    end else begin
                        e = (i == 0) ? q0.pop_front() : q1.pop_front();
                        chk(rsp_hit == e.hit, e.rq, "hit", 64'(rsp_hit), 64'(e.hit));
                        chk(rsp_fault == e.fault, e.rq, "fault", 64'(rsp_fault), 64'(e.fault));
                        chk(rsp_pa == e.pa, e.rq, "pa", 64'(rsp_pa), 64'(e.pa));
                    end
                end
            end
        end
    end

    function automatic exp_t mk(input bit h, input bit f, input logic [VPN_W-1:0] ppn,
                                input logic [PAGE_BITS-1:0] off, input string rq);
        exp_t x;
        x.hit   = h;
        x.fault = f;
        x.pa    = h ? {ppn, off} : '0;
        x.rq    = rq;
        return x;
    endfunction

    task automatic set_req(input int id, input logic [VPN_W-1:0] vpn,
                           input logic [PAGE_BITS-1:0] off,
                           input logic [ASID_W-1:0] asid, input logic [TID_W-1:0] tid);
        req_va[id*VA_W +: VA_W]       = {vpn, off};
        req_asid[id*ASID_W +: ASID_W] = asid;
        req_tid[id*TID_W +: TID_W]    = tid;
        req_valid[id]                 = 1'b1;
    endtask

    // driver: pushes the expected item, then drives one lookup cycle
    task automatic lookup(input int id, input logic [VPN_W-1:0] vpn,
                          input logic [PAGE_BITS-1:0] off,
                          input logic [ASID_W-1:0] asid, input logic [TID_W-1:0] tid,
                          input bit h, input bit f, input logic [PPN_W-1:0] ppn,
                          input string rq);
        if (id == 0) q0.push_back(mk(h, f, ppn, off, rq));
        else         q1.push_back(mk(h, f, ppn, off, rq));
        set_req(id, vpn, off, asid, tid);
        @(negedge clk);
        req_valid[id] = 1'b0;
    endtask

    task automatic wr(input logic [VPN_W-1:0] vpn, input logic [ASID_W-1:0] asid,
                      input logic [TID_W-1:0] own, input logic [PPN_W-1:0] ppn);
        wr_vpn   = vpn;
        wr_asid  = asid;
        wr_sasid = own;
        wr_ppn   = ppn;
        wr_en    = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic flush(input bit all, input logic [ASID_W-1:0] asid);
        flush_all  = all;
        flush_asid = asid;
        flush_en   = 1'b1;
        @(negedge clk);
        flush_en = 1'b0;
    endtask

    function automatic logic [VPN_W-1:0] s9(input int k);
        return VPN_W'((k << IDX_W) | 9);
    endfunction

    initial begin
        repeat (100000) @(posedge clk);
        chk(1'b0, "watchdog", "timeout", 0, 1);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst = 1'b1;
        req_valid = '0; req_va = '0; req_asid = '0; req_tid = '0;
        wr_en = 1'b0; wr_vpn = '0; wr_asid = '0; wr_sasid = '0; wr_ppn = '0;
        flush_en = 1'b0; flush_all = 1'b0; flush_asid = '0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1: quiet outputs and an empty table after reset
        chk(rsp_valid == '0, "R1", "rsp_valid", 64'(rsp_valid), 0);
        chk(req_stall == '0, "R1", "req_stall", 64'(req_stall), 0);
        lookup(0, 20'h00123, 12'h456, 8'd5, 4'd3, 0, 0, 0, "R1");

        // R4: hit that keeps the page offset
        wr(20'h00123, 8'd5, 4'd0, 20'hABCDE);
        lookup(0, 20'h00123, 12'h456, 8'd5, 4'd3, 1, 0, 20'hABCDE, "R4");
        lookup(1, 20'h00123, 12'hFFF, 8'd5, 4'd9, 1, 0, 20'hABCDE, "R4");
        // R5: a different ASID misses
        lookup(0, 20'h00123, 12'h456, 8'd6, 4'd3, 0, 0, 0, "R5");
        // R7: another tag in the same set misses
        lookup(0, 20'h00143, 12'h000, 8'd5, 4'd3, 0, 0, 0, "R7");

        // R6: a page owned by thread 7
        wr(20'h00244, 8'd5, 4'd7, 20'h11111);
        lookup(0, 20'h00244, 12'h010, 8'd5, 4'd7, 1, 0, 20'h11111, "R6");
        lookup(1, 20'h00244, 12'h010, 8'd5, 4'd2, 0, 1, 0, "R6");

        // R8: fill set 9, tags 1..8 go into ways 0..7
        for (int k = 1; k <= 8; k++) wr(s9(k), 8'd1, 4'd0, 20'(32'h200 + k));
        for (int k = 1; k <= 8; k++)
            lookup(0, s9(k), 12'h0, 8'd1, 4'd0, 1, 0, 20'(32'h200 + k), "R8");

        // R9: a full set evicts way 0, then way 1
        wr(s9(9), 8'd1, 4'd0, 20'h209);
        lookup(0, s9(1), 12'h0, 8'd1, 4'd0, 0, 0, 0, "R9");
        lookup(0, s9(9), 12'h0, 8'd1, 4'd0, 1, 0, 20'h209, "R9");
        wr(s9(10), 8'd1, 4'd0, 20'h20A);
        lookup(0, s9(2), 12'h0, 8'd1, 4'd0, 0, 0, 0, "R9");
        lookup(0, s9(3), 12'h0, 8'd1, 4'd0, 1, 0, 20'h203, "R9");

        // R10: overwrite tag 3 in place; the pointer still names way 2
        wr(s9(3), 8'd1, 4'd0, 20'h00333);
        lookup(0, s9(3), 12'h7, 8'd1, 4'd0, 1, 0, 20'h00333, "R10");
        for (int k = 4; k <= 10; k++)
            lookup(0, s9(k), 12'h0, 8'd1, 4'd0, 1, 0, 20'(32'h200 + k), "R10");
        wr(s9(11), 8'd1, 4'd0, 20'h20B);
        lookup(0, s9(3), 12'h0, 8'd1, 4'd0, 0, 0, 0, "R10");
        lookup(0, s9(4), 12'h0, 8'd1, 4'd0, 1, 0, 20'h204, "R10");
        lookup(0, s9(11), 12'h0, 8'd1, 4'd0, 1, 0, 20'h20B, "R10");

        // R11: flush ASID 5 only, owned page included
        wr(20'h00123, 8'd2, 4'd0, 20'h77777);
        flush(1'b0, 8'd5);
        lookup(0, 20'h00123, 12'h456, 8'd5, 4'd3, 0, 0, 0, "R11");
        lookup(0, 20'h00244, 12'h010, 8'd5, 4'd7, 0, 0, 0, "R11");
        lookup(0, 20'h00123, 12'h456, 8'd2, 4'd3, 1, 0, 20'h77777, "R11");
        lookup(0, s9(4), 12'h0, 8'd1, 4'd0, 1, 0, 20'h204, "R11");

        // R3: both requesters at once; port 0 first, port 1 held
        q0.push_back(mk(1, 0, 20'h77777, 12'h001, "R3"));
        q1.push_back(mk(1, 0, 20'h205, 12'h002, "R3"));
        set_req(0, 20'h00123, 12'h001, 8'd2, 4'd0);
        set_req(1, s9(5), 12'h002, 8'd1, 4'd0);
        #1;
        chk(req_stall == 2'b10, "R3", "stall both", 64'(req_stall), 64'h2);
        @(negedge clk);
        chk(rsp_valid == 2'b01, "R3", "first rsp", 64'(rsp_valid), 64'h1);
        req_valid[0] = 1'b0;
        #1;
        chk(req_stall == 2'b00, "R3", "stall released", 64'(req_stall), 0);
        @(negedge clk);
        chk(rsp_valid == 2'b10, "R2", "second rsp", 64'(rsp_valid), 64'h2);
        req_valid[1] = 1'b0;

        // R2: a lookup in the write cycle sees the old table
        q0.push_back(mk(0, 0, 0, 12'h0, "R2"));
        set_req(0, 20'h00555, 12'h0, 8'd3, 4'd0);
        wr_vpn = 20'h00555; wr_asid = 8'd3; wr_sasid = 4'd0; wr_ppn = 20'h55555; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        req_valid[0] = 1'b0;
        lookup(0, 20'h00555, 12'h0AB, 8'd3, 4'd0, 1, 0, 20'h55555, "R2");

        // R12: flush everything while a write lands
        wr_vpn = 20'h00066; wr_asid = 8'd3; wr_sasid = 4'd0; wr_ppn = 20'h06666; wr_en = 1'b1;
        flush_all = 1'b1; flush_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0; flush_en = 1'b0;
        lookup(0, 20'h00555, 12'h0, 8'd3, 4'd0, 0, 0, 0, "R12");
        lookup(0, s9(4), 12'h0, 8'd1, 4'd0, 0, 0, 0, "R12");
        lookup(1, 20'h00123, 12'h0, 8'd2, 4'd0, 0, 0, 0, "R12");
        lookup(0, 20'h00066, 12'h321, 8'd3, 4'd0, 1, 0, 20'h06666, "R12");

        repeat (3) @(negedge clk);
        chk(q0.size() == 0, "R2", "port 0 responses pending", 64'(q0.size()), 0);
        chk(q1.size() == 0, "R2", "port 1 responses pending", 64'(q1.size()), 0);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule